// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Register

This block is the digital input stage of a two-channel 16-bit converter. A host with an 8-bit data bus writes each channel's 16-bit code as two bytes. The bytes may be written in either order, and either channel may be loaded first. Each channel has its own chip select and write strobe. Three shared active-low enables choose what an access does: capture the low byte, capture the high byte, or transfer the word to the output. Each channel keeps a first rank of two byte latches and a second-rank output register. The second rank drives the channel's two's-complement converter code, so new bytes reach the output only when a transfer is requested.

All strobes are sampled on one system clock. A per-channel strobe state machine turns each qualified access into a single action. It has two states. `ST_ARMED` waits for an access. It takes transition `GRAB` to `ST_HELD` in the cycle where chip select and write are both low, and that cycle performs the action. `ST_HELD` ignores the held strobe. It takes transition `RELEASE` back to `ST_ARMED` once chip select or write goes high. An asynchronous active-low clear forces both output registers to 0000h, which is bipolar zero in two's-complement coding. Clear leaves the byte latches as they are.

Top module: `dual_dac_front`

## Requirements
- R1: After `rst_n` is released, both output codes read 0000h and the byte latches hold zero.
- R2: An access (`cs_n[ch]` and `wr_n[ch]` both low) with `lo_en_n` low stores `bus_byte` as bits 7..0 of that channel's word.
- R3: An access with `hi_en_n` low stores `bus_byte` as bits 15..8 of that channel's word.
- R4: Every control input is active low. Chip select low with write high, or write low with chip select high, changes neither the latches nor the output.
- R5: An access to one channel leaves the other channel's latches and output unchanged.
- R6: The low and high bytes may be written in either order, with the same resulting word.
- R7: Byte writes alone never change an output code. A channel's output changes only on the clock edge that ends an access cycle with `xfer_en_n` low, and it becomes {high byte, low byte}.
- R8: A byte written in the same access cycle as a transfer is included in the transferred word.
- R9: `clr_n` low forces both output codes to 0000h at once, without waiting for a clock edge. The byte latches are kept, so a later transfer-only access restores the stored word.
- R10: While `clr_n` is low, a transfer access leaves the output at 0000h. Byte writes made in the same access are still stored.
- R11: A strobe held low across several cycles acts only in its first cycle. Bus changes while it is held are ignored, and the strobe must go high before the next access takes effect.
- R12: An access with both `lo_en_n` and `hi_en_n` low writes the bus byte into both halves of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| clr_n | input | 1 | Asynchronous active-low clear of both output codes |
| bus_byte | input | 8 | Shared data byte |
| lo_en_n | input | 1 | Active-low low-byte capture enable |
| hi_en_n | input | 1 | Active-low high-byte capture enable |
| xfer_en_n | input | 1 | Active-low transfer enable from the first rank to the output |
| cs_n | input | 2 | Active-low chip select, one bit per channel |
| wr_n | input | 2 | Active-low write strobe, one bit per channel |
| code_out | output | 32 | Output codes: channel 0 in bits 15..0, channel 1 in bits 31..16, two's complement |

## Verification
The hardest case to reach from the ports is a stored word surviving a clear. The bench must show that the first rank kept its bytes while the output read zero. It does this by holding clear across a transfer access, releasing clear, and then issuing a transfer-only access: the old word must reappear without any byte being rewritten. The one-shot strobe behaviour is also awkward to observe. The bench holds chip select and write low over several edges while it changes the bus, and the following transfer shows which byte was latched. Both channels, both write orders and a spread of arithmetic data patterns are swept. After every byte write, the bench confirms that the outputs have not moved.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } strobe_st_t;

    localparam int unsigned LANES = 2;
endpackage

// File: rtl/dacfe_strobe_fsm.sv
module dacfe_strobe_fsm
    import dacfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic wr_n,
    output logic fire
);
    strobe_st_t state_q;
    strobe_st_t state_d;
    logic       access;

    assign access = ~sel_n & ~wr_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: GRAB (armed -> held), RELEASE (held -> armed)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (access)  state_d = ST_HELD;
            ST_HELD:  if (!access) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // outputs: one action on the first cycle of an access
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_ARMED: fire = access;
            ST_HELD:  fire = 1'b0;
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacfe_byte_rank.sv
module dacfe_byte_rank
    import dacfe_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic [BYTE_W-1:0] bus,
    output logic [WORD_W-1:0] word_q,
    output logic [WORD_W-1:0] word_nx
);
    logic [LANES-1:0] lane_hit;

    assign lane_hit = {~hi_en_n, ~lo_en_n} & {LANES{fire}};

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (lane_hit[ln]) begin
                lane_q <= bus;
            end
        end

        assign word_q[ln*BYTE_W +: BYTE_W]  = lane_q;
        assign word_nx[ln*BYTE_W +: BYTE_W] = lane_hit[ln] ? bus : lane_q;
    end
endmodule

// File: rtl/dacfe_out_rank.sv
module dacfe_out_rank #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] code
);
    logic zero_n;

    assign zero_n = rst_n & clr_n;

    always_ff @(posedge clk or negedge zero_n) begin
        if (!zero_n) begin
            code <= '0;
        end else if (load) begin
            code <= word_in;
        end
    end
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dacfe_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = LANES * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic [BYTE_W-1:0]     bus_byte,
    input  logic                  lo_en_n,
    input  logic                  hi_en_n,
    input  logic                  xfer_en_n,
    input  logic [NCH-1:0]        cs_n,
    input  logic [NCH-1:0]        wr_n,
    output logic [NCH*WORD_W-1:0] code_out
);
    logic [NCH-1:0]        fire;
    logic [NCH*WORD_W-1:0] word_q;
    logic [NCH*WORD_W-1:0] word_nx;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dacfe_strobe_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_n (cs_n[ch]),
            .wr_n  (wr_n[ch]),
            .fire  (fire[ch])
        );

        dacfe_byte_rank #(.BYTE_W(BYTE_W)) u_rank1 (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (fire[ch]),
            .lo_en_n (lo_en_n),
            .hi_en_n (hi_en_n),
            .bus     (bus_byte),
            .word_q  (word_q[ch*WORD_W +: WORD_W]),
            .word_nx (word_nx[ch*WORD_W +: WORD_W])
        );

        dacfe_out_rank #(.WORD_W(WORD_W)) u_rank2 (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_n   (clr_n),
            .load    (fire[ch] & ~xfer_en_n),
            .word_in (word_nx[ch*WORD_W +: WORD_W]),
            .code    (code_out[ch*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int unsigned NCH    = 2,
    parameter int unsigned WORD_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr_n,
    input logic                  xfer_en_n,
    input logic [NCH-1:0]        cs_n,
    input logic [NCH-1:0]        wr_n,
    input logic [NCH-1:0]        fire,
    input logic [NCH*WORD_W-1:0] word_q,
    input logic [NCH*WORD_W-1:0] word_nx,
    input logic [NCH*WORD_W-1:0] code_out
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_n |-> code_out[ch*WORD_W +: WORD_W] == '0);

        assert_hold_without_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_n && $past(clr_n) && $past(xfer_en_n || cs_n[ch] || wr_n[ch]))
            |-> $stable(code_out[ch*WORD_W +: WORD_W]));

        assert_xfer_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_n && $past(clr_n) && $past(fire[ch] && !xfer_en_n))
            |-> code_out[ch*WORD_W +: WORD_W] == $past(word_nx[ch*WORD_W +: WORD_W]));

        assert_held_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && clr_n && $past(clr_n) &&
             $past(!cs_n[ch] && !wr_n[ch], 1) && $past(!cs_n[ch] && !wr_n[ch], 2))
            |-> $stable(code_out[ch*WORD_W +: WORD_W]));

        assert_latch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(fire[ch]) |-> $stable(word_q[ch*WORD_W +: WORD_W]));
    end
endmodule

bind dual_dac_front dacfe_checker #(.NCH(NCH), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .xfer_en_n (xfer_en_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .fire      (fire),
    .word_q    (word_q),
    .word_nx   (word_nx),
    .code_out  (code_out)
);

// File: tb/sim_dual_dac_front.sv
module sim_dual_dac_front;
    logic        clk = 1'b0;
    logic        rst_n, clr_n, lo_en_n, hi_en_n, xfer_en_n;
    logic [7:0]  bus_byte;
    logic [1:0]  cs_n, wr_n;
    logic [31:0] code_out;

    int unsigned nchecks = 0;
    int unsigned nerrors = 0;
    logic [7:0]  m_lo [2];
    logic [7:0]  m_hi [2];
    logic [15:0] m_code [2];

    dual_dac_front u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .bus_byte(bus_byte),
        .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .xfer_en_n(xfer_en_n),
        .cs_n(cs_n), .wr_n(wr_n), .code_out(code_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_both(input string req);
        chk(req, code_out[15:0],  m_code[0]);
        chk(req, code_out[31:16], m_code[1]);
    endtask

    task automatic idle_bus();
        cs_n = 2'b11; wr_n = 2'b11;
        lo_en_n = 1'b1; hi_en_n = 1'b1; xfer_en_n = 1'b1;
    endtask

    // one access of one cycle, then one idle cycle; model updated
    task automatic access(input int ch, input bit lo, input bit hi, input bit xf,
                          input logic [7:0] b);
        @(negedge clk);
        cs_n[ch] = 1'b0; wr_n[ch] = 1'b0;
        lo_en_n = ~lo; hi_en_n = ~hi; xfer_en_n = ~xf; bus_byte = b;
        @(negedge clk);
        idle_bus();
        if (lo) m_lo[ch] = b;
        if (hi) m_hi[ch] = b;
        if (xf && clr_n) m_code[ch] = {m_hi[ch], m_lo[ch]};
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        nerrors++;
        nchecks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr_n = 1'b1; bus_byte = '0;
        idle_bus();
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_code[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_both("R1 reset");
        access(0, 0, 0, 1, 8'h00);
        chk_both("R1 latches zero");

        // sweep: channels, orders, data patterns
        for (int ch = 0; ch < 2; ch++) begin
            for (int ord = 0; ord < 2; ord++) begin
                for (int k = 0; k < 24; k++) begin
                    logic [15:0] w;
                    w = 16'((k * 16'h2F1B) ^ (ch * 16'h8001) ^ (ord * 16'h0F0F));
                    if (ord == 0) begin
                        access(ch, 1, 0, 0, w[7:0]);
                        chk_both("R2 R7 low byte, output held");
                        access(ch, 0, 1, 0, w[15:8]);
                        chk_both("R3 R7 high byte, output held");
                    end else begin
                        access(ch, 0, 1, 0, w[15:8]);
                        chk_both("R6 R7 high first, output held");
                        access(ch, 1, 0, 0, w[7:0]);
                        chk_both("R6 R7 low second, output held");
                    end
                    access(ch, 0, 0, 1, 8'h00);
                    chk(ord ? "R6 transfer" : "R2 R3 transfer",
                        code_out[ch*16 +: 16], w);
                    chk_both("R5 other channel unchanged");
                end
            end
        end

        // R8: same-cycle byte and transfer
        access(1, 1, 0, 0, 8'h34);
        access(1, 0, 1, 1, 8'hA5);
        chk("R8 same-cycle byte", code_out[31:16], 16'hA534);
        chk_both("R8 both");

        // R12: both enables
        access(0, 1, 1, 1, 8'h7E);
        chk("R12 both halves", code_out[15:0], 16'h7E7E);

        // R4: half-qualified accesses
        @(negedge clk);
        cs_n[0] = 1'b0; wr_n[0] = 1'b1; lo_en_n = 1'b0; xfer_en_n = 1'b0; bus_byte = 8'h11;
        @(negedge clk);
        idle_bus();
        cs_n[0] = 1'b1; wr_n[0] = 1'b0; hi_en_n = 1'b0; xfer_en_n = 1'b0; bus_byte = 8'h22;
        @(negedge clk);
        idle_bus();
        @(negedge clk);
        chk_both("R4 no access, output");
        access(0, 0, 0, 1, 8'h00);
        chk("R4 latches untouched", code_out[15:0], 16'h7E7E);

        // R11: held strobe acts once
        @(negedge clk);
        cs_n[0] = 1'b0; wr_n[0] = 1'b0; lo_en_n = 1'b0; bus_byte = 8'h5A;
        @(negedge clk);
        bus_byte = 8'hC3; xfer_en_n = 1'b0;
        @(negedge clk);
        bus_byte = 8'h99;
        @(negedge clk);
        chk("R11 held transfer ignored", code_out[15:0], 16'h7E7E);
        idle_bus();
        m_lo[0] = 8'h5A;
        @(negedge clk);
        access(0, 0, 0, 1, 8'h00);
        chk("R11 first byte only", code_out[15:0], 16'h7E5A);

        // R9: asynchronous clear, then restore
        access(1, 0, 0, 1, 8'h00);
        #1 clr_n = 1'b0;
        #0.5;
        chk("R9 async clear ch0", code_out[15:0], 16'h0000);
        chk("R9 async clear ch1", code_out[31:16], 16'h0000);
        // R10: transfer during clear has no output effect, byte still stored
        access(1, 1, 0, 1, 8'h0C);
        chk("R10 clear wins over transfer", code_out[31:16], 16'h0000);
        @(negedge clk);
        clr_n = 1'b1;
        m_code[0] = '0; m_code[1] = '0;
        @(negedge clk);
        chk_both("R9 stays zero after release");
        access(0, 0, 0, 1, 8'h00);
        chk("R9 restored ch0", code_out[15:0], 16'h7E5A);
        access(1, 0, 0, 1, 8'h00);
        chk("R10 byte kept during clear", code_out[31:16], 16'hA50C);

        $display("  Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end
endmodule